// File: doc/BRIEF.md
# Windowed Identical-Bit Run Detector

This block takes a 32-bit packet and finds every long stretch of identical consecutive bits in it, so that a serial-link transmitter can send such a stretch as a short length code instead of bit by bit. A start strobe captures the packet. The block then examines the packet one 8-comparison window per clock cycle. In each window, 2-input XOR gates compare every bit with its upper neighbour, and a per-window detector reduces the XOR pattern to a compact record. When all windows are recorded, a stitching stage joins the pieces of runs that cross window borders. It produces the final list of runs that meet the compression threshold.

The list goes out one entry per beat on a valid/ready handshake. Each beat carries the start index and length of one run, and a flag marks the final entry. The transmitter consumes the beats and then strobes the next packet.

Top module: `bitrun_finder`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `run_valid` is low.
- R2: Every maximal stretch of identical bits whose length is at least MIN_RUN (8) is reported exactly once. `run_start` is the index of its lowest bit, where bit 0 is the packet LSB. `run_len` is its length in bits. A stretch that reaches bit 31 ends at the packet end. Stretches shorter than MIN_RUN are never reported.
- R3: A run that spans one or more borders between the 8-bit windows (bits 0-7, 8-15, 16-23, 24-31) is reported as a single entry with its true start and full length.
- R4: Entries come out in strictly ascending start order, and no entry begins before the previous entry ends.
- R5: `run_last` is 1 on the final entry of the list and 0 on every other entry. A packet with no qualifying run yields exactly one beat with `run_start` = 0, `run_len` = 0 and `run_last` = 1.
- R6: The first beat appears on `run_valid` exactly NWIN+1 = 5 rising edges after the edge that accepts `start`: one edge per window and one for stitching.
- R7: While `run_valid` is high and `run_ready` is low, `run_valid`, `run_start`, `run_len` and `run_last` hold their values.
- R8: A `start` that arrives while a scan is running or a list is still being delivered is ignored, and the list in progress is not changed.
- R9: In the cycle after the beat with `run_last` = 1 is accepted, `run_valid` is low and the block accepts a new `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pkt_in | input | 32 | Packet to scan, sampled with `start` |
| start | input | 1 | Begins a scan when the block is idle |
| run_ready | input | 1 | Consumer accepts the current beat |
| run_valid | output | 1 | A run entry (or the empty marker) is presented |
| run_start | output | 5 | Lowest bit index of the presented run |
| run_len | output | 6 | Length of the presented run in bits, 0 for the empty marker |
| run_last | output | 1 | The presented entry is the final one of the list |

## Verification
On every cycle, the assertions check several properties. Beats hold steady under backpressure, and reported lengths respect the threshold and the packet bounds. Successive entries do not overlap, an empty marker is always final, and the first beat arrives after exactly NWIN+1 edges. The scenarios are needed for the content of the list. Only a per-packet comparison against an independent bit-walk of the packet can show that the right runs are found, that border-crossing runs are merged, and that short runs are dropped. Only timed stimulus shows that a strobe issued mid-scan or mid-delivery leaves the list untouched.

// File: rtl/bitrun_pkg.sv
package bitrun_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SCAN   = 2'd1,
    ST_STITCH = 2'd2,
    ST_DRAIN  = 2'd3
  } scan_state_e;

  // number of clear comparator outputs below the lowest set one (n if none)
  function automatic int low_zeros(input logic [63:0] v, input int n);
    int  cnt;
    bit  hit;
    cnt = 0;
    hit = 1'b0;
    for (int i = 0; i < 64; i++) begin
      if (i < n && !hit) begin
        if (v[i]) hit = 1'b1;
        else      cnt = cnt + 1;
      end
    end
    return cnt;
  endfunction

  // number of clear comparator outputs above the highest set one (n if none)
  function automatic int high_zeros(input logic [63:0] v, input int n);
    int  cnt;
    bit  hit;
    cnt = 0;
    hit = 1'b0;
    for (int i = 63; i >= 0; i--) begin
      if (i < n && !hit) begin
        if (v[i]) hit = 1'b1;
        else      cnt = cnt + 1;
      end
    end
    return cnt;
  endfunction

  // bit length of a run closed by a change: equal pairs before, plus head, plus one
  function automatic int closed_len(input int pairs_before, input int head);
    return pairs_before + head + 1;
  endfunction

  // first bit of the run opened after the highest change in a window
  function automatic int reopen_at(input int win, input int win_cmp, input int tail);
    return win * win_cmp + win_cmp - tail;
  endfunction

endpackage

// File: rtl/bitrun_window.sv
module bitrun_window #(
  parameter int WIN_CMP = 8,
  parameter int CNT_W   = $clog2(WIN_CMP + 1)
) (
  input  logic [WIN_CMP:0]   win_bits,
  output logic [WIN_CMP-1:0] diff,
  output logic               has_edge,
  output logic [CNT_W-1:0]   head_zeros,
  output logic [CNT_W-1:0]   tail_zeros
);
  import bitrun_pkg::*;

  // one 2-input XOR per adjacent bit pair
  for (genvar g = 0; g < WIN_CMP; g++) begin : g_cmp
    assign diff[g] = win_bits[g] ^ win_bits[g+1];
  end

  always_comb begin
    has_edge   = |diff;
    head_zeros = CNT_W'(low_zeros(64'(diff), WIN_CMP));
    tail_zeros = CNT_W'(high_zeros(64'(diff), WIN_CMP));
  end

endmodule

// File: rtl/bitrun_stitch.sv
module bitrun_stitch #(
  parameter int WIN_CMP = 8,
  parameter int NWIN    = 4,
  parameter int MIN_RUN = 8,
  parameter int MAXR    = 4,
  parameter int IDX_W   = 5,
  parameter int LEN_W   = 6,
  parameter int CNT_W   = 4,
  parameter int NUM_W   = 3
) (
  input  logic [NWIN-1:0]  rec_edge,
  input  logic [CNT_W-1:0] rec_head [NWIN],
  input  logic [CNT_W-1:0] rec_tail [NWIN],
  output logic [IDX_W-1:0] lst_start [MAXR],
  output logic [LEN_W-1:0] lst_len   [MAXR],
  output logic [NUM_W-1:0] lst_num
);
  import bitrun_pkg::*;

  always_comb begin
    int open_at;
    int pairs;
    int n;
    int len;
    open_at = 0;
    pairs   = 0;
    n       = 0;
    len     = 0;
    for (int m = 0; m < MAXR; m++) begin
      lst_start[m] = '0;
      lst_len[m]   = '0;
    end
    for (int w = 0; w < NWIN; w++) begin
      if (!rec_edge[w]) begin
        pairs = pairs + WIN_CMP;
      end else begin
        len = closed_len(pairs, int'(rec_head[w]));
        if (len >= MIN_RUN) begin
          for (int m = 0; m < MAXR; m++) begin
            if (m == n) begin
              lst_start[m] = IDX_W'(open_at);
              lst_len[m]   = LEN_W'(len);
            end
          end
          if (n < MAXR) n = n + 1;
        end
        open_at = reopen_at(w, WIN_CMP, int'(rec_tail[w]));
        pairs   = int'(rec_tail[w]);
      end
    end
    lst_num = NUM_W'(n);
  end

endmodule

// File: rtl/bitrun_port.sv
module bitrun_port #(
  parameter int MAXR  = 4,
  parameter int IDX_W = 5,
  parameter int LEN_W = 6,
  parameter int NUM_W = 3,
  parameter int PTR_W = (MAXR > 1) ? $clog2(MAXR) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] lst_start [MAXR],
  input  logic [LEN_W-1:0] lst_len   [MAXR],
  input  logic [NUM_W-1:0] lst_num,
  input  logic             run_ready,
  output logic             run_valid,
  output logic [IDX_W-1:0] run_start,
  output logic [LEN_W-1:0] run_len,
  output logic             run_last,
  output logic             beat_fire,
  output logic             list_done
);

  logic [IDX_W-1:0] q_start [MAXR];
  logic [LEN_W-1:0] q_len   [MAXR];
  logic [NUM_W-1:0] q_num;
  logic [PTR_W-1:0] ptr;
  logic             valid_q;
  logic             empty;

  always_comb begin
    empty     = (q_num == '0);
    run_valid = valid_q;
    run_last  = empty || ((NUM_W'(ptr) + NUM_W'(1)) == q_num);
    run_start = empty ? '0 : q_start[ptr];
    run_len   = empty ? '0 : q_len[ptr];
    beat_fire = valid_q && run_ready;
    list_done = beat_fire && run_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ptr     <= '0;
      q_num   <= '0;
      for (int m = 0; m < MAXR; m++) begin
        q_start[m] <= '0;
        q_len[m]   <= '0;
      end
    end else if (load) begin
      valid_q <= 1'b1;
      ptr     <= '0;
      q_num   <= lst_num;
      for (int m = 0; m < MAXR; m++) begin
        q_start[m] <= lst_start[m];
        q_len[m]   <= lst_len[m];
      end
    end else if (beat_fire) begin
      if (run_last) valid_q <= 1'b0;
      else          ptr     <= ptr + PTR_W'(1);
    end
  end

endmodule

// File: rtl/bitrun_finder.sv
module bitrun_finder #(
  parameter int PKT_W   = 32,
  parameter int WIN_CMP = 8,
  parameter int MIN_RUN = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [PKT_W-1:0]           pkt_in,
  input  logic                       start,
  input  logic                       run_ready,
  output logic                       run_valid,
  output logic [$clog2(PKT_W)-1:0]   run_start,
  output logic [$clog2(PKT_W+1)-1:0] run_len,
  output logic                       run_last
);
  import bitrun_pkg::*;

  localparam int NWIN  = PKT_W / WIN_CMP;
  localparam int MAXR  = PKT_W / MIN_RUN;
  localparam int IDX_W = $clog2(PKT_W);
  localparam int LEN_W = $clog2(PKT_W + 1);
  localparam int CNT_W = $clog2(WIN_CMP + 1);
  localparam int NUM_W = $clog2(MAXR + 1);
  localparam int WI_W  = (NWIN > 1) ? $clog2(NWIN) : 1;

  if (PKT_W % WIN_CMP != 0) begin : g_bad_split
    $error("packet width must be a whole number of windows");
  end
  if (MIN_RUN < WIN_CMP) begin : g_bad_threshold
    $error("threshold below window size would need interior run records");
  end

  scan_state_e      state;
  logic [PKT_W-1:0] pkt_q;
  logic [WI_W-1:0]  win_idx;
  logic [PKT_W:0]   pkt_ext;
  logic [WIN_CMP:0] win_bits;

  // event wires for the checker
  logic start_take;
  logic win_store;
  logic stitch_load;
  logic beat_fire;
  logic list_done;

  logic [WIN_CMP-1:0] diff;
  logic               det_edge;
  logic [CNT_W-1:0]   det_head;
  logic [CNT_W-1:0]   det_tail;

  logic [NWIN-1:0]    rec_edge;
  logic [CNT_W-1:0]   rec_head [NWIN];
  logic [CNT_W-1:0]   rec_tail [NWIN];

  logic [IDX_W-1:0]   lst_start [MAXR];
  logic [LEN_W-1:0]   lst_len   [MAXR];
  logic [NUM_W-1:0]   lst_num;

  always_comb begin
    // bit above the MSB differs from it, so the last pair always closes a run
    pkt_ext     = {~pkt_q[PKT_W-1], pkt_q};
    win_bits    = pkt_ext[int'(win_idx) * WIN_CMP +: WIN_CMP + 1];
    start_take  = start && (state == ST_IDLE);
    win_store   = (state == ST_SCAN);
    stitch_load = (state == ST_STITCH);
  end

  bitrun_window #(
    .WIN_CMP (WIN_CMP),
    .CNT_W   (CNT_W)
  ) u_window (
    .win_bits   (win_bits),
    .diff       (diff),
    .has_edge   (det_edge),
    .head_zeros (det_head),
    .tail_zeros (det_tail)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      pkt_q   <= '0;
      win_idx <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_take) begin
            pkt_q   <= pkt_in;
            win_idx <= '0;
            state   <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (win_idx == WI_W'(NWIN - 1)) state <= ST_STITCH;
          else                            win_idx <= win_idx + WI_W'(1);
        end
        ST_STITCH: state <= ST_DRAIN;
        ST_DRAIN:  if (list_done) state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  // sequence registers: one record per window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_edge <= '0;
      for (int w = 0; w < NWIN; w++) begin
        rec_head[w] <= '0;
        rec_tail[w] <= '0;
      end
    end else if (win_store) begin
      for (int w = 0; w < NWIN; w++) begin
        if (win_idx == WI_W'(w)) begin
          rec_edge[w] <= det_edge;
          rec_head[w] <= det_head;
          rec_tail[w] <= det_tail;
        end
      end
    end
  end

  bitrun_stitch #(
    .WIN_CMP (WIN_CMP),
    .NWIN    (NWIN),
    .MIN_RUN (MIN_RUN),
    .MAXR    (MAXR),
    .IDX_W   (IDX_W),
    .LEN_W   (LEN_W),
    .CNT_W   (CNT_W),
    .NUM_W   (NUM_W)
  ) u_stitch (
    .rec_edge  (rec_edge),
    .rec_head  (rec_head),
    .rec_tail  (rec_tail),
    .lst_start (lst_start),
    .lst_len   (lst_len),
    .lst_num   (lst_num)
  );

  bitrun_port #(
    .MAXR  (MAXR),
    .IDX_W (IDX_W),
    .LEN_W (LEN_W),
    .NUM_W (NUM_W)
  ) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (stitch_load),
    .lst_start (lst_start),
    .lst_len   (lst_len),
    .lst_num   (lst_num),
    .run_ready (run_ready),
    .run_valid (run_valid),
    .run_start (run_start),
    .run_len   (run_len),
    .run_last  (run_last),
    .beat_fire (beat_fire),
    .list_done (list_done)
  );

endmodule

// File: rtl/bitrun_finder_chk.sv
module bitrun_finder_chk #(
  parameter int PKT_W   = 32,
  parameter int NWIN    = 4,
  parameter int MIN_RUN = 8,
  parameter int IDX_W   = 5,
  parameter int LEN_W   = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_take,
  input logic             beat_fire,
  input logic             run_valid,
  input logic             run_ready,
  input logic [IDX_W-1:0] run_start,
  input logic [LEN_W-1:0] run_len,
  input logic             run_last
);

  // edges since a start was accepted; NWIN+2 when sampled on the edge after valid rises
  localparam int LAT_W = $clog2(NWIN + 4);
  logic [LAT_W-1:0] lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      lat <= '0;
    else if (start_take)             lat <= LAT_W'(1);
    else if (run_valid)              lat <= '0;
    else if (lat != '0)              lat <= lat + LAT_W'(1);
  end

  // R7
  hold_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_valid && !run_ready) |=> (run_valid && $stable(run_start) &&
                                   $stable(run_len) && $stable(run_last)));

  // R5
  empty_is_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_valid && run_len == '0) |-> (run_last && run_start == '0));

  // R2
  len_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_valid && run_len != '0) |-> (int'(run_len) >= MIN_RUN &&
                                      int'(run_start) + int'(run_len) <= PKT_W));

  // R4
  ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && !run_last) |=> (run_valid &&
      int'(run_start) >= int'($past(run_start)) + int'($past(run_len))));

  // R6
  first_beat_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_valid) |-> (int'(lat) == NWIN + 2));

  // R9
  list_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && run_last) |=> !run_valid);

endmodule

bind bitrun_finder bitrun_finder_chk #(
  .PKT_W   (PKT_W),
  .NWIN    (NWIN),
  .MIN_RUN (MIN_RUN),
  .IDX_W   (IDX_W),
  .LEN_W   (LEN_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_take (start_take),
  .beat_fire  (beat_fire),
  .run_valid  (run_valid),
  .run_ready  (run_ready),
  .run_start  (run_start),
  .run_len    (run_len),
  .run_last   (run_last)
);

// File: tb/bitrun_finder_bench.sv
module bitrun_finder_bench;

  localparam int PKT_W   = 32;
  localparam int MIN_RUN = 8;
  localparam int NWIN    = 4;
  localparam int NVEC    = 10;

  // {packet, number of qualifying runs}
  localparam logic [35:0] VEC [NVEC] = '{
    {32'h0000_0000, 4'd1},
    {32'hFFFF_0000, 4'd2},
    {32'hAAAA_AAAA, 4'd0},
    {32'h0000_00FF, 4'd2},
    {32'h00FF_00FF, 4'd4},
    {32'h0000_007F, 4'd1},
    {32'h8000_0001, 4'd1},
    {32'h0F0F_0F0F, 4'd0},
    {32'hFF80_1FF0, 4'd3},
    {32'hFFFF_FF00, 4'd2}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        run_ready = 1'b0;
  logic [31:0] pkt_in = '0;
  logic        run_valid;
  logic [4:0]  run_start;
  logic [5:0]  run_len;
  logic        run_last;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  int exp_start [8];
  int exp_len   [8];
  int exp_n;

  always #4 clk = ~clk;

  bitrun_finder u_bitrun_finder (
    .clk       (clk),
    .rst_n     (rst_n),
    .pkt_in    (pkt_in),
    .start     (start),
    .run_ready (run_ready),
    .run_valid (run_valid),
    .run_start (run_start),
    .run_len   (run_len),
    .run_last  (run_last)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // bit walk: a stretch ends where the next bit differs or the packet ends
  function automatic void build_ref(input logic [31:0] p);
    int st;
    exp_n = 0;
    st = 0;
    for (int i = 1; i <= PKT_W; i++) begin
      if (i == PKT_W || p[i] != p[st]) begin
        if (i - st >= MIN_RUN) begin
          exp_start[exp_n] = st;
          exp_len[exp_n]   = i - st;
          exp_n++;
        end
        st = i;
      end
    end
  endfunction

  task automatic launch(input logic [31:0] p);
    @(negedge clk);
    pkt_in = p;
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
  endtask

  task automatic wait_valid(output int lat);
    lat = 0;
    while (!run_valid && lat < 50) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic drain(input logic [31:0] p, input int tbl_n);
    int beats;
    int prev_end;
    build_ref(p);
    check(exp_n == tbl_n, "R2 table count", exp_n, tbl_n);
    beats = (exp_n == 0) ? 1 : exp_n;
    prev_end = 0;
    run_ready = 1'b1;
    for (int k = 0; k < beats; k++) begin
      check(run_valid == 1'b1, "R2 beat present", run_valid, 1);
      if (exp_n == 0) begin
        check(run_len == 6'd0, "R5 empty len", run_len, 0);
        check(run_start == 5'd0, "R5 empty start", run_start, 0);
        check(run_last == 1'b1, "R5 empty last", run_last, 1);
      end else begin
        check(int'(run_start) == exp_start[k], "R2 start", run_start, exp_start[k]);
        check(int'(run_len) == exp_len[k], "R3 length", run_len, exp_len[k]);
        check(run_last == (k == exp_n - 1), "R5 last flag", run_last, int'(k == exp_n - 1));
        if (k > 0) check(int'(run_start) >= prev_end, "R4 order", run_start, prev_end);
        prev_end = int'(run_start) + int'(run_len);
      end
      @(negedge clk);
    end
    check(run_valid == 1'b0, "R9 valid drops", run_valid, 0);
    run_ready = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog (all requirements): actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int lat;
    logic [4:0] s0;
    logic [5:0] l0;
    logic       t0;

    // reset state
    repeat (3) @(negedge clk);
    check(run_valid == 1'b0, "R1 in reset", run_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(run_valid == 1'b0, "R1 after release", run_valid, 0);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      launch(VEC[v][35:4]);
      wait_valid(lat);
      check(lat == NWIN + 1, "R6 latency", lat, NWIN + 1);
      drain(VEC[v][35:4], int'(VEC[v][3:0]));
    end

    // backpressure holds the beat (R7)
    launch(32'h00FF_00FF);
    wait_valid(lat);
    s0 = run_start;
    l0 = run_len;
    t0 = run_last;
    repeat (3) begin
      @(negedge clk);
      check(run_valid == 1'b1, "R7 valid held", run_valid, 1);
      check(run_start == s0 && run_len == l0 && run_last == t0, "R7 beat held",
            {run_start, run_len}, {s0, l0});
    end
    drain(32'h00FF_00FF, 4);

    // strobes during scan and during delivery are ignored (R8)
    launch(32'h0000_00FF);
    pkt_in = 32'hAAAA_AAAA;
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    wait_valid(lat);
    pkt_in = 32'hFFFF_FFFF;
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    @(negedge clk);
    check(run_len == 6'd8 && run_start == 5'd0, "R8 list unchanged", run_len, 8);
    drain(32'h0000_00FF, 2);
    check(run_valid == 1'b0, "R8 no extra list", run_valid, 0);

    // immediate restart after the last beat (R9)
    launch(32'h0000_0000);
    wait_valid(lat);
    check(lat == NWIN + 1, "R9 restart latency", lat, NWIN + 1);
    drain(32'h0000_0000, 1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule